// File: doc/BRIEF.md
# Dual-Mode Modem Host Port with Checked Configuration Load

This block is the slave-side host port of a half-duplex modem. One static strap chooses how the same group of pins is used. In the first form it is a nibble-wide parallel port with a strobe and a read/write line. In the second form it is an SPI slave: the strobe pin carries the serial clock, and the read/write pin sets the clock polarity. The chip-select polarity and the interrupt polarity are both chosen by straps. The strobe, the serial clock, chip-select and the incoming data lines all pass through two-flop synchronizers into the master clock domain. Every transfer is then decided by edge detection in that domain.

On the modem side there are two byte queues. Bytes the host writes go into the transmit queue, which the modem drains. Bytes the modem receives go into the receive queue, which the host reads. The interrupt and a data-available flag report that receive data is pending. In SPI mode, the data-available, line-busy and port-busy flags appear on data lines that are not needed for the serial transfer.

A reserved command byte starts a configuration load. The next 19 host bytes are captured into a small configuration memory instead of going to the transmit queue. A CRC-16 over the first 17 of those bytes is compared with the last two bytes. A configuration-done output rises only when the two match.

Top module: `hostport_top`

## Requirements
- R1: With `port_sel` high, the port works as a parallel port on `d_in[3:0]`/`d_out[3:0]`. With `port_sel` low, it works as an SPI slave: MOSI is `d_in[3]`, MISO is `d_out[4]` and the serial clock is `strb_sclk_in`.
- R2: Chip-select is active when `cs_in` equals `cs_pol`. Strobes and serial clock edges are ignored while chip-select is inactive.
- R3: A parallel write (`rw_cpol_in` low) takes two rising strobe edges. The first carries the high nibble and the second the low nibble. The assembled byte is appended to the transmit queue, and the modem sees it on `tx_byte` while `tx_valid` is high.
- R4: During a parallel read (`rw_cpol_in` high), `d_out[3:0]` shows the high nibble of the oldest pending receive byte. After one rising strobe edge it shows the low nibble. The second rising strobe edge removes the byte. With no byte pending, the lines read 0 and strobes change nothing.
- R5: SPI frames are 8 bits long and MSB first. MOSI is sampled on the leading clock edge: rising when `rw_cpol_in` is 0, falling when it is 1. MISO shifts out the oldest pending receive byte, which is removed at the end of the frame, or 0x00 if none was pending. Outside a configuration load, a received 0x00 is a dummy byte and is not queued.
- R6: In SPI mode, `d_out[0]` is high while receive data is pending, `d_out[1]` follows `line_busy`, and `d_out[2]` is high while the transmit queue is full.
- R7: `irq_out` sits at the level of `irq_pol` while any receive byte is pending. It returns to the opposite level only after the host has read the last pending byte.
- R8: A host byte equal to 0xF5, outside a configuration load, starts a load. The byte is not queued, and `cfg_done` goes low.
- R9: The 19 host bytes that follow the command are stored at addresses 0 to 18 and are not queued. Each can be read on `cfg_rd_data` one clock after its address is placed on `cfg_rd_addr`. Host bytes after the 19th are queued as normal.
- R10: `cfg_done` goes high after the 19th byte only if CRC-16 (polynomial 0x1021, initial value 0xFFFF, MSB first, no final inversion) over bytes 0 to 16 equals byte 17 (high half) followed by byte 18 (low half). Otherwise it stays low.
- R11: `hsk_oe` is high only while chip-select is active. In parallel mode, `d_oe[3:0]` is high during an active read. In SPI mode, `d_oe[2:0]` is always high and `d_oe[4]` is high only with chip-select active. `hsk_out` follows the synchronized strobe in parallel mode, and marks a frame boundary in SPI mode.
- R12: A host byte that arrives while the transmit queue is full is dropped. The bytes already queued are kept in order.
- R13: After reset, both queues are empty, `cfg_done` is low, `irq_out` is at its inactive level and `hsk_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| port_sel | input | 1 | Strap: 1 selects parallel, 0 selects SPI |
| cs_pol | input | 1 | Strap: level at which chip-select is active |
| irq_pol | input | 1 | Strap: active level of the interrupt |
| cs_in | input | 1 | Chip-select from the host |
| strb_sclk_in | input | 1 | Parallel strobe, or SPI serial clock |
| rw_cpol_in | input | 1 | Parallel read (1) / write (0), or SPI clock polarity |
| d_in | input | 4 | Incoming data lines (MOSI on bit 3 in SPI mode) |
| d_out | output | 5 | Outgoing data lines: nibble, or SPI flags and MISO |
| d_oe | output | 5 | Per-line drive enable for `d_out` |
| hsk_out | output | 1 | Handshake level |
| hsk_oe | output | 1 | Drive enable for the handshake line |
| irq_out | output | 1 | Interrupt, polarity set by `irq_pol` |
| cfg_done | output | 1 | Configuration captured and CRC verified |
| cfg_rd_addr | input | CFG_AW | Configuration memory read address |
| cfg_rd_data | output | 8 | Configuration byte, one clock after the address |
| line_busy | input | 1 | Line-busy status from the modem |
| rx_wr | input | 1 | Modem pushes a received byte |
| rx_byte | input | 8 | Byte pushed by the modem |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_rd | input | 1 | Modem takes the oldest transmit byte |

## Verification
The bench targets the points where a faulty port fails without any obvious sign.

- A frame or read that finds no pending byte must not remove anything. Popping on empty would corrupt the queue pointers.
- The interrupt must stay asserted across the first of two pending bytes. Clearing it on any read would lose the second byte.
- A write into a full transmit queue must be dropped without losing queued bytes. Overwriting the oldest entry would reorder the data.
- The configuration path is tested with a correct CRC and then a corrupted one. A checker that skipped the comparison, or mixed up the order of the two check bytes, would raise `cfg_done` in the wrong case.
- SPI transfers are run at both clock polarities. Sampling on the wrong edge would shift the byte by one bit.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  // Byte-at-a-time CRC-16 update, MSB first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      s1 <= din[i];
      s2 <= s1;
    end
    assign dout[i] = s2;
  end
endmodule

// File: rtl/hp_fifo.sv
module hp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R12: a push into a full queue leaves the fill level alone
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> $stable(cnt))
    else $error("queue overflow changed level");

  // R4: a pop on an empty queue has no effect
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty)
    else $error("queue underflow changed level");
endmodule

// File: rtl/hp_cfg.sv
module hp_cfg import hp_pkg::*; #(
  parameter int LEN = 19,
  parameter int AW  = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr,
  input  logic [7:0]    din,
  output logic          busy,
  output logic          done,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int CRC_LEN = LEN - 2;

  logic [7:0]    mem [LEN];
  logic [AW-1:0] idx;
  logic [15:0]   crc;
  logic [7:0]    exp_hi;
  logic          take;

  assign take = busy & wr;

  always_ff @(posedge clk) begin
    if (take) mem[idx] <= din;
    rd_data <= (int'(rd_addr) < LEN) ? mem[rd_addr] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      idx    <= '0;
      crc    <= CRC_SEED;
      exp_hi <= 8'h00;
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
      idx  <= '0;
      crc  <= CRC_SEED;
    end else if (take) begin
      idx <= idx + AW'(1);
      if (int'(idx) < CRC_LEN)       crc    <= crc16_step(crc, din);
      else if (int'(idx) == CRC_LEN) exp_hi <= din;
      if (int'(idx) == LEN - 1) begin
        busy <= 1'b0;
        done <= (crc == {exp_hi, din});
      end
    end
  end

  // R10: done is never high while a load is in progress
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done)
    else $error("done high during load");

  // R10: done rises only as the result of a captured byte
  assert_done_source_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(take))
    else $error("done rose without a byte");
endmodule

// File: rtl/hostport_top.sv
module hostport_top import hp_pkg::*; #(
  parameter int         TXQ_DEPTH = 8,
  parameter int         RXQ_DEPTH = 8,
  parameter int         CFG_LEN   = 19,
  parameter int         CFG_AW    = $clog2(CFG_LEN),
  parameter logic [7:0] RST_CMD   = 8'hF5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_sel,
  input  logic              cs_pol,
  input  logic              irq_pol,
  input  logic              cs_in,
  input  logic              strb_sclk_in,
  input  logic              rw_cpol_in,
  input  logic [3:0]        d_in,
  output logic [4:0]        d_out,
  output logic [4:0]        d_oe,
  output logic              hsk_out,
  output logic              hsk_oe,
  output logic              irq_out,
  output logic              cfg_done,
  input  logic [CFG_AW-1:0] cfg_rd_addr,
  output logic [7:0]        cfg_rd_data,
  input  logic              line_busy,
  input  logic              rx_wr,
  input  logic [7:0]        rx_byte,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_rd
);
  localparam int SW = 7;

  // ---------------- synchronizers and edge detect ----------------
  logic [SW-1:0] raw_v, sync_v;
  logic          cs_act, strb_s, rw_s;
  logic [3:0]    dat_s;
  logic          cs_act_q, strb_q;
  logic          cs_rise, strb_rise, strb_fall;
  logic          par_mode, par_ev, spi_lead;

  assign raw_v = {cs_in, strb_sclk_in, rw_cpol_in, d_in};

  hp_sync #(.W(SW)) u_sync (
    .clk  (clk),
    .din  (raw_v),
    .dout (sync_v)
  );

  assign cs_act = (sync_v[6] == cs_pol);
  assign strb_s = sync_v[5];
  assign rw_s   = sync_v[4];
  assign dat_s  = sync_v[3:0];

  always_ff @(posedge clk) begin
    cs_act_q <= cs_act;
    strb_q   <= strb_s;
  end

  assign cs_rise   = cs_act & ~cs_act_q & ~rst;
  assign strb_rise = strb_s & ~strb_q;
  assign strb_fall = ~strb_s & strb_q;
  assign par_mode  = port_sel;
  assign par_ev    = par_mode & cs_act & strb_rise & ~rst;
  assign spi_lead  = ~par_mode & cs_act & ~rst & (rw_s ? strb_fall : strb_rise);

  // ---------------- queues ----------------
  logic       rxq_empty, rxq_full, txq_empty, txq_full;
  logic [7:0] rxq_head;
  logic       tx_push, host_pop;
  logic [7:0] host_byte;

  hp_fifo #(.DW(8), .DEPTH(RXQ_DEPTH)) u_rxq (
    .clk   (clk),
    .rst   (rst),
    .push  (rx_wr),
    .din   (rx_byte),
    .pop   (host_pop),
    .head  (rxq_head),
    .empty (rxq_empty),
    .full  (rxq_full)
  );

  hp_fifo #(.DW(8), .DEPTH(TXQ_DEPTH)) u_txq (
    .clk   (clk),
    .rst   (rst),
    .push  (tx_push),
    .din   (host_byte),
    .pop   (tx_rd),
    .head  (tx_byte),
    .empty (txq_empty),
    .full  (txq_full)
  );

  assign tx_valid = ~txq_empty;

  // ---------------- parallel engine ----------------
  logic       nib_ph;
  logic [3:0] nib_hi;
  logic       par_wr_vld, par_pop;

  always_ff @(posedge clk) begin
    if (rst || !cs_act || !par_mode) begin
      nib_ph <= 1'b0;
    end else if (par_ev) begin
      if (!rw_s) begin
        if (!nib_ph) nib_hi <= dat_s;
        nib_ph <= ~nib_ph;
      end else if (!rxq_empty) begin
        nib_ph <= ~nib_ph;
      end
    end
  end

  assign par_wr_vld = par_ev & ~rw_s & nib_ph;
  assign par_pop    = par_ev & rw_s & nib_ph & ~rxq_empty;

  // ---------------- SPI engine ----------------
  logic [2:0] bit_cnt;
  logic [6:0] sh_in;
  logic [7:0] sh_out;
  logic       frame_pop, reload;
  logic       spi_done, spi_pop;
  logic [7:0] spi_byte;

  always_ff @(posedge clk) begin
    if (rst || !cs_act || par_mode) begin
      bit_cnt   <= '0;
      frame_pop <= 1'b0;
      reload    <= 1'b0;
      if (rst) sh_out <= 8'h00;
    end else if (cs_rise || reload) begin
      sh_out    <= rxq_empty ? 8'h00 : rxq_head;
      frame_pop <= ~rxq_empty;
      reload    <= 1'b0;
    end else if (spi_lead) begin
      sh_in   <= {sh_in[5:0], dat_s[3]};
      sh_out  <= {sh_out[6:0], 1'b0};
      bit_cnt <= bit_cnt + 3'd1;
      if (bit_cnt == 3'd7) reload <= 1'b1;
    end
  end

  assign spi_done = spi_lead & (bit_cnt == 3'd7) & ~cs_rise & ~reload;
  assign spi_byte = {sh_in, dat_s[3]};
  assign spi_pop  = spi_done & frame_pop;
  assign host_pop = par_pop | spi_pop;

  // ---------------- byte routing ----------------
  logic host_vld, cfg_busy, cfg_start, cfg_wr;

  assign host_vld  = par_wr_vld | spi_done;
  assign host_byte = par_mode ? {nib_hi, dat_s} : spi_byte;
  assign cfg_wr    = host_vld & cfg_busy;
  assign cfg_start = host_vld & ~cfg_busy & (host_byte == RST_CMD);
  assign tx_push   = host_vld & ~cfg_busy & (host_byte != RST_CMD)
                   & ~(~par_mode & (host_byte == 8'h00));

  hp_cfg #(.LEN(CFG_LEN), .AW(CFG_AW)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .start   (cfg_start),
    .wr      (cfg_wr),
    .din     (host_byte),
    .busy    (cfg_busy),
    .done    (cfg_done),
    .rd_addr (cfg_rd_addr),
    .rd_data (cfg_rd_data)
  );

  // ---------------- registered pin outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      d_out   <= '0;
      d_oe    <= '0;
      hsk_out <= 1'b0;
      hsk_oe  <= 1'b0;
      irq_out <= ~irq_pol;
    end else begin
      irq_out <= rxq_empty ? ~irq_pol : irq_pol;
      hsk_oe  <= cs_act;
      if (par_mode) begin
        d_out   <= {1'b0, rxq_empty ? 4'h0 : (nib_ph ? rxq_head[3:0] : rxq_head[7:4])};
        d_oe    <= {1'b0, {4{cs_act & rw_s}}};
        hsk_out <= cs_act & strb_s;
      end else begin
        d_out   <= {sh_out[7], 1'b0, txq_full, line_busy, ~rxq_empty};
        d_oe    <= {cs_act, 1'b0, 3'b111};
        hsk_out <= cs_act & (bit_cnt == 3'd0);
      end
    end
  end

  // R7: pending receive data drives the interrupt to its active level
  assert_irq_pending_R7: assert property (@(posedge clk) disable iff (rst)
    !rxq_empty |=> irq_out == irq_pol)
    else $error("interrupt not active with data pending");

  // R4: the host side only removes bytes that exist
  assert_pop_pending_R4: assert property (@(posedge clk) disable iff (rst)
    host_pop |-> !rxq_empty)
    else $error("host pop with empty queue");

  // R11: handshake and MISO float while chip-select is inactive
  assert_hsk_float_R11: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (!hsk_oe && !d_oe[4]))
    else $error("drive enable with chip-select inactive");

  // R5: a completed frame returns the bit counter to the frame start
  assert_frame_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    spi_done |=> bit_cnt == 3'd0)
    else $error("bit counter did not wrap");

  // R9: no host byte reaches the transmit queue during a load
  assert_cfg_swallow_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_busy |=> !($rose(tx_valid)) || !$past(cfg_busy) || !$past(host_vld))
    else $error("configuration byte leaked to queue");

  logic unused_ok;
  assign unused_ok = rxq_full;
endmodule

// File: tb/tb_hostport_top.sv
module tb_hostport_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, port_sel, cs_pol, irq_pol, cs_in, strb_sclk_in, rw_cpol_in;
  logic [3:0] d_in;
  logic [4:0] d_out, d_oe;
  logic       hsk_out, hsk_oe, irq_out, cfg_done;
  logic [4:0] cfg_rd_addr;
  logic [7:0] cfg_rd_data;
  logic       line_busy, rx_wr, tx_valid, tx_rd;
  logic [7:0] rx_byte, tx_byte;

  hostport_top dut (
    .clk(clk), .rst(rst), .port_sel(port_sel), .cs_pol(cs_pol), .irq_pol(irq_pol),
    .cs_in(cs_in), .strb_sclk_in(strb_sclk_in), .rw_cpol_in(rw_cpol_in),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .hsk_out(hsk_out), .hsk_oe(hsk_oe),
    .irq_out(irq_out), .cfg_done(cfg_done), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rd_data(cfg_rd_data), .line_busy(line_busy), .rx_wr(rx_wr),
    .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_rd(tx_rd)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] cfg_b[19];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_set(input bit act);
    cs_in = act ? cs_pol : ~cs_pol;
  endtask

  // bit-serial CRC model
  function automatic logic [15:0] crc_model(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ cfg_b[k][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  task automatic par_write(input logic [7:0] b);
    rw_cpol_in = 1'b0; cs_set(1); d_in = b[7:4]; tick(4);
    strb_sclk_in = 1'b1; tick(6); strb_sclk_in = 1'b0; tick(4);
    d_in = b[3:0]; tick(2);
    strb_sclk_in = 1'b1; tick(6); strb_sclk_in = 1'b0; tick(6);
    cs_set(0); tick(4);
  endtask

  task automatic par_read(output logic [7:0] b);
    rw_cpol_in = 1'b1; cs_set(1); tick(6);
    chk("R11 read drive enable", {27'd0, d_oe}, 32'h0F);
    b[7:4] = d_out[3:0];
    strb_sclk_in = 1'b1; tick(6);
    chk("R11 hsk follows strobe", {30'd0, hsk_oe, hsk_out}, 32'h3);
    strb_sclk_in = 1'b0; tick(6);
    b[3:0] = d_out[3:0];
    strb_sclk_in = 1'b1; tick(6); strb_sclk_in = 1'b0; tick(6);
    cs_set(0); rw_cpol_in = 1'b0; tick(4);
  endtask

  task automatic spi_xfer(input logic [7:0] t, output logic [7:0] r);
    logic cpol = rw_cpol_in;
    strb_sclk_in = cpol; cs_set(1); tick(8);
    for (int i = 7; i >= 0; i--) begin
      d_in[3] = t[i]; tick(4);
      r[i] = d_out[4];
      strb_sclk_in = ~cpol; tick(4);
      strb_sclk_in = cpol;
    end
    tick(8); cs_set(0); tick(8);
  endtask

  task automatic modem_push(input logic [7:0] b);
    rx_wr = 1'b1; rx_byte = b; tick(1); rx_wr = 1'b0; tick(1);
  endtask

  task automatic drain(input string req);
    tick(2);
    while (tx_valid) begin
      if (exp_tx.size() == 0) chk(req, {24'd0, tx_byte}, 32'hFFFF_FFFF);
      else chk(req, {24'd0, tx_byte}, {24'd0, exp_tx.pop_front()});
      tx_rd = 1'b1; tick(1); tx_rd = 1'b0; tick(1);
    end
    chk({req, " queue drained"}, exp_tx.size(), 0);
    exp_tx.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [15:0] crc;
    rst = 1; port_sel = 1; cs_pol = 1; irq_pol = 1; cs_in = 0; strb_sclk_in = 0;
    rw_cpol_in = 0; d_in = 0; cfg_rd_addr = 0; line_busy = 0; rx_wr = 0; rx_byte = 0; tx_rd = 0;
    tick(6); rst = 0; tick(2);
    // R13 reset state
    chk("R13 irq inactive", irq_out, 0);
    chk("R13 cfg_done", cfg_done, 0);
    chk("R13 tx_valid", tx_valid, 0);
    chk("R13 hsk_oe", hsk_oe, 0);

    // R1 R3 parallel writes
    par_write(8'h3C); exp_tx.push_back(8'h3C);
    par_write(8'hA7); exp_tx.push_back(8'hA7);
    drain("R3 parallel write");

    // R2 strobes with chip-select inactive are ignored
    rw_cpol_in = 0; cs_set(0); d_in = 4'h9;
    repeat (4) begin strb_sclk_in = 1; tick(6); strb_sclk_in = 0; tick(6); end
    chk("R2 inactive cs ignored", tx_valid, 0);
    chk("R11 hsk_oe low without cs", hsk_oe, 0);

    // R4 R7 parallel reads
    modem_push(8'h5E); modem_push(8'h81); tick(3);
    chk("R7 irq active high", irq_out, 1);
    par_read(r); chk("R4 read first", r, 8'h5E);
    chk("R7 irq held with data left", irq_out, 1);
    par_read(r); chk("R4 read second", r, 8'h81);
    tick(3); chk("R7 irq cleared", irq_out, 0);
    par_read(r); chk("R4 read empty", r, 8'h00);
    modem_push(8'h24); tick(3);
    par_read(r); chk("R4 empty read left queue intact", r, 8'h24);

    // R2 R7 active-low chip-select and interrupt
    cs_pol = 0; irq_pol = 0; cs_set(0); tick(6);
    chk("R7 active-low idle", irq_out, 1);
    par_write(8'h42); exp_tx.push_back(8'h42);
    drain("R2 active-low cs write");

    // SPI mode, cpol 0: fill to overflow
    port_sel = 0; rw_cpol_in = 0; strb_sclk_in = 0; tick(6);
    chk("R11 SPI flag enables", {27'd0, d_oe}, 32'h07);
    for (int i = 0; i < 8; i++) begin
      spi_xfer(8'h11 + 8'(i), r); exp_tx.push_back(8'h11 + 8'(i));
      chk("R5 idle MISO", r, 8'h00);
    end
    chk("R6 port busy flag", d_out[2], 1);
    spi_xfer(8'hEE, r); spi_xfer(8'hEE, r);
    drain("R12 overflow dropped");
    chk("R6 port busy cleared", d_out[2], 0);

    // R5 R6 SPI read with dummy byte
    modem_push(8'h96); tick(3);
    chk("R6 data available", d_out[0], 1);
    chk("R7 active-low asserted", irq_out, 0);
    spi_xfer(8'h00, r);
    chk("R5 MISO byte", r, 8'h96);
    chk("R5 dummy not queued", tx_valid, 0);
    chk("R6 data available cleared", d_out[0], 0);
    line_busy = 1; tick(3);
    chk("R6 line busy", d_out[1], 1);
    line_busy = 0;

    // R5 cpol 1
    rw_cpol_in = 1; strb_sclk_in = 1; tick(6);
    modem_push(8'hC3); tick(3);
    spi_xfer(8'h6B, r); exp_tx.push_back(8'h6B);
    chk("R5 cpol1 MISO", r, 8'hC3);
    drain("R5 cpol1 MOSI");

    // R8 R9 R10 configuration through SPI, good CRC
    for (int i = 0; i < 17; i++) cfg_b[i] = 8'(i * 29 + 5);
    crc = crc_model(17); cfg_b[17] = crc[15:8]; cfg_b[18] = crc[7:0];
    spi_xfer(8'hF5, r);
    chk("R8 cfg_done low after command", cfg_done, 0);
    for (int i = 0; i < 19; i++) spi_xfer(cfg_b[i], r);
    tick(2);
    chk("R10 good CRC done", cfg_done, 1);
    chk("R9 bytes not queued", tx_valid, 0);
    for (int a = 0; a < 19; a += 6) begin
      cfg_rd_addr = 5'(a); tick(2);
      chk("R9 config readback", cfg_rd_data, cfg_b[a]);
    end

    // R8 R10 parallel load with corrupted CRC
    port_sel = 1; rw_cpol_in = 0; strb_sclk_in = 0; tick(6);
    par_write(8'hF5);
    chk("R8 command clears done", cfg_done, 0);
    cfg_b[18] = cfg_b[18] ^ 8'h01;
    for (int i = 0; i < 19; i++) par_write(cfg_b[i]);
    tick(2);
    chk("R10 bad CRC stays low", cfg_done, 0);
    par_write(8'h77); exp_tx.push_back(8'h77);
    drain("R9 bytes after load queued");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule